// File: doc/BRIEF.md
# Serial command and result readout front end for a multichannel SAR converter

This block is the serial control port of a multichannel successive-approximation converter. A host drives a mode-0 style serial link (select, clock, data in, data out). While the select line is low, every eight clock bits form one command byte. The first set bit in the byte picks which configuration register the byte updates, so the register is chosen by how many zeros lead the byte, not by an address field. The stored fields leave the block as steady outputs for the conversion engine. A write to the conversion register also raises a one-cycle start strobe.

In the same frame the block returns conversion results on the data-out line. Each result is 12 bits wide and travels as a 16-bit word, most significant bit first, behind four zero bits. Results come from an external queue over a valid/data pair. The block pulses a pop strobe once a whole word has left the pin, and the queue then offers its next entry. The serial inputs are asynchronous and are synchronized into the system clock, which must run at least four times faster than the serial clock. Edges of the serial clock are detected in the system clock domain.

Top module: `adc_spi_ctrl`

## Requirements
- R1: Data in is sampled on rising serial-clock edges and assembled MSB first. Each group of 8 bits while select is low is one command, and several commands may follow one another within a single select-low frame.
- R2: After reset, clock mode reads 2'b10. Channel, scan, temperature, reference, differential-select, averaging, unipolar-pair and bipolar-pair fields all read 0. The strobes and the output enable are low.
- R3: A byte `1cccc ss t` (bit 7 set) loads the channel from bits 6:3, the scan mode from bits 2:1 and the temperature request from bit 0. It also gives exactly one one-cycle conv_start pulse.
- R4: A byte `01kk rrdd` loads clock mode from bits 5:4, reference mode from bits 3:2 and differential select from bits 1:0.
- R5: A byte `001e nnxx` loads avg_en from bit 4 and avg_cnt from bits 3:2. Bits 1:0 are ignored.
- R6: A byte `0001 fxxx` gives one queue_flush pulse. When f = 0 it also restores every configuration field to its reset value. When f = 1 no field changes.
- R7: A byte `00001uuu` loads uni_pairs from bits 2:0. A byte `000001bb` loads bip_pairs from bits 1:0.
- R8: A byte with seven or eight leading zeros (0000001x or 00000000) changes no field and gives no strobe.
- R9: Raising select clears the bit count and drops a partially received byte. The next byte starts fresh after select falls again.
- R10: A readout word is 16 bits: four zeros, then the 12-bit result, MSB first. The first bit is on data out once select falls, and each following bit appears after a falling serial-clock edge.
- R11: If a result was loaded into the word, res_pop pulses for one cycle after the word's 16th rising edge. The next queue entry then follows in the same frame.
- R12: If no result is valid when a word is loaded, the word is all zeros and no pop is given.
- R13: dout_oe is low while select is high, and high during a frame.
- R14: Raising select before a word's 16th rising edge gives no pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Serial select, active low |
| din | input | 1 | Serial data from host |
| dout | output | 1 | Serial data to host |
| dout_oe | output | 1 | Drive enable for dout |
| res_data | input | 12 | Result at head of queue |
| res_valid | input | 1 | Queue holds a result |
| res_pop | output | 1 | One-cycle pop of the queue head |
| conv_start | output | 1 | One-cycle start strobe |
| chan_sel | output | 4 | Channel select |
| scan_mode | output | 2 | Scan mode |
| temp_req | output | 1 | Temperature measurement request |
| clk_mode | output | 2 | Clock mode |
| ref_mode | output | 2 | Reference mode |
| diff_sel | output | 2 | Differential register selection |
| avg_en | output | 1 | Averaging enable |
| avg_cnt | output | 2 | Averaging count code |
| uni_pairs | output | 3 | Unipolar differential pairs |
| bip_pairs | output | 2 | Bipolar differential pairs |
| queue_flush | output | 1 | One-cycle queue flush strobe |

## Verification
The hardest state to reach is a select-low frame that crosses a word boundary. At that point the pop, the queue's next entry and the reload on the following falling edge must line up. The bench reaches it by holding select low for 32 clocks while a small model of the queue advances on every pop, and it checks both words bit by bit. A 10-clock frame then covers the early-release case: the pop must not appear, and the partial byte on data in is dropped. Because data in stays low during readout, these frames also push all-zero command bytes, which must leave every field unchanged.

// File: rtl/adc_spi_pkg.sv
package adc_spi_pkg;
  localparam int CMD_W = 8;

  typedef struct packed {
    logic [3:0] chan;
    logic [1:0] scan;
    logic       temp;
  } conv_cfg_t;

  typedef struct packed {
    logic [1:0] clk_mode;
    logic [1:0] ref_mode;
    logic [1:0] diff_sel;
  } setup_cfg_t;

  typedef struct packed {
    logic       en;
    logic [1:0] cnt;
  } avg_cfg_t;

  localparam conv_cfg_t  CONV_DEF  = '{chan: 4'd0, scan: 2'd0, temp: 1'b0};
  localparam setup_cfg_t SETUP_DEF = '{clk_mode: 2'b10, ref_mode: 2'b00, diff_sel: 2'b00};
  localparam avg_cfg_t   AVG_DEF   = '{en: 1'b0, cnt: 2'd0};

  typedef enum logic [2:0] {
    K_CONV  = 3'd0,
    K_SETUP = 3'd1,
    K_AVG   = 3'd2,
    K_RST   = 3'd3,
    K_UNI   = 3'd4,
    K_BIP   = 3'd5,
    K_NONE  = 3'd7
  } cmd_kind_t;

  // kind = number of zeros ahead of the first set bit, up to five
  function automatic cmd_kind_t classify(input logic [CMD_W-1:0] b);
    cmd_kind_t k;
    logic hit;
    k = K_NONE;
    hit = 1'b0;
    for (int i = CMD_W - 1; i >= 2; i--) begin
      if (!hit && b[i]) begin
        hit = 1'b1;
        k = cmd_kind_t'(3'(CMD_W - 1 - i));
      end
    end
    return k;
  endfunction
endpackage

// File: rtl/adc_spi_sync.sv
module adc_spi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic din,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic cs_start,
  output logic din_s
);
  logic [STAGES-1:0] sclk_q, cs_q, din_q;
  logic sclk_d, cs_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          sclk_q <= '0;
          cs_q   <= '1;
          din_q  <= '0;
        end else begin
          sclk_q <= sclk;
          cs_q   <= cs_n;
          din_q  <= din;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          sclk_q <= '0;
          cs_q   <= '1;
          din_q  <= '0;
        end else begin
          sclk_q <= {sclk_q[STAGES-2:0], sclk};
          cs_q   <= {cs_q[STAGES-2:0], cs_n};
          din_q  <= {din_q[STAGES-2:0], din};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_q[STAGES-1];
      cs_d   <= cs_q[STAGES-1];
    end
  end

  assign sclk_rise = sclk_q[STAGES-1] & ~sclk_d;
  assign sclk_fall = ~sclk_q[STAGES-1] & sclk_d;
  assign cs_act    = ~cs_q[STAGES-1];
  assign cs_start  = ~cs_q[STAGES-1] & cs_d;
  assign din_s     = din_q[STAGES-1];
endmodule

// File: rtl/adc_spi_rx.sv
module adc_spi_rx
  import adc_spi_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_act,
  input  logic             sclk_rise,
  input  logic             din_s,
  output logic             byte_vld,
  output logic [CMD_W-1:0] byte_data
);
  localparam int CNT_W = $clog2(CMD_W);

  logic [CMD_W-2:0] sh;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      cnt       <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (!cs_act) begin
        sh  <= '0;
        cnt <= '0;
      end else if (sclk_rise) begin
        if (cnt == CNT_W'(CMD_W - 1)) begin
          byte_vld  <= 1'b1;
          byte_data <= {sh, din_s};
          cnt       <= '0;
          sh        <= '0;
        end else begin
          sh  <= {sh[CMD_W-3:0], din_s};
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_spi_regs.sv
module adc_spi_regs
  import adc_spi_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_vld,
  input  logic [CMD_W-1:0] byte_data,
  output conv_cfg_t        conv,
  output setup_cfg_t       setup,
  output avg_cfg_t         avg,
  output logic [2:0]       uni,
  output logic [1:0]       bip,
  output logic             start,
  output logic             flush
);
  cmd_kind_t kind;
  logic      unused_bits;

  assign kind        = classify(byte_data);
  assign unused_bits = ^{byte_data[1:0], byte_data[2]};

  always_ff @(posedge clk) begin
    if (rst) begin
      conv  <= CONV_DEF;
      setup <= SETUP_DEF;
      avg   <= AVG_DEF;
      uni   <= '0;
      bip   <= '0;
      start <= 1'b0;
      flush <= 1'b0;
    end else begin
      start <= 1'b0;
      flush <= 1'b0;
      if (byte_vld) begin
        unique case (kind)
          K_CONV: begin
            conv  <= '{chan: byte_data[6:3], scan: byte_data[2:1], temp: byte_data[0]};
            start <= 1'b1;
          end
          K_SETUP: setup <= '{clk_mode: byte_data[5:4], ref_mode: byte_data[3:2],
                              diff_sel: byte_data[1:0]};
          K_AVG:   avg   <= '{en: byte_data[4], cnt: byte_data[3:2]};
          K_RST: begin
            flush <= 1'b1;
            if (!byte_data[3]) begin
              conv  <= CONV_DEF;
              setup <= SETUP_DEF;
              avg   <= AVG_DEF;
              uni   <= '0;
              bip   <= '0;
            end
          end
          K_UNI:   uni <= byte_data[2:0];
          K_BIP:   bip <= byte_data[1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_spi_tx.sv
module adc_spi_tx #(
  parameter int DATA_W  = 12,
  parameter int FRAME_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              cs_start,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic [DATA_W-1:0] res_data,
  input  logic              res_valid,
  output logic              res_pop,
  output logic              dout,
  output logic              dout_oe
);
  localparam int PAD_W = FRAME_W - DATA_W;
  localparam int CNT_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   bcnt;
  logic               loaded, need;
  logic [FRAME_W-1:0] word_in;

  assign word_in = res_valid ? {{PAD_W{1'b0}}, res_data} : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      bcnt    <= '0;
      loaded  <= 1'b0;
      need    <= 1'b0;
      res_pop <= 1'b0;
      dout_oe <= 1'b0;
    end else begin
      res_pop <= 1'b0;
      dout_oe <= cs_act;
      if (cs_start) begin
        sh     <= word_in;
        loaded <= res_valid;
        bcnt   <= '0;
        need   <= 1'b0;
      end else if (!cs_act) begin
        bcnt   <= '0;
        need   <= 1'b0;
        loaded <= 1'b0;
      end else begin
        if (sclk_rise) begin
          if (bcnt == CNT_W'(FRAME_W - 1)) begin
            bcnt    <= '0;
            need    <= 1'b1;
            res_pop <= loaded;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        if (sclk_fall) begin
          if (need) begin
            sh     <= word_in;
            loaded <= res_valid;
            need   <= 1'b0;
          end else begin
            sh <= {sh[FRAME_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign dout = sh[FRAME_W-1];
endmodule

// File: rtl/adc_spi_ctrl.sv
module adc_spi_ctrl
  import adc_spi_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int FRAME_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  output logic              dout,
  output logic              dout_oe,
  input  logic [DATA_W-1:0] res_data,
  input  logic              res_valid,
  output logic              res_pop,
  output logic              conv_start,
  output logic [3:0]        chan_sel,
  output logic [1:0]        scan_mode,
  output logic              temp_req,
  output logic [1:0]        clk_mode,
  output logic [1:0]        ref_mode,
  output logic [1:0]        diff_sel,
  output logic              avg_en,
  output logic [1:0]        avg_cnt,
  output logic [2:0]        uni_pairs,
  output logic [1:0]        bip_pairs,
  output logic              queue_flush
);
  logic             sclk_rise, sclk_fall, cs_act, cs_start, din_s;
  logic             byte_vld;
  logic [CMD_W-1:0] byte_data;
  conv_cfg_t        conv;
  setup_cfg_t       setup;
  avg_cfg_t         avg;

  adc_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_act(cs_act), .cs_start(cs_start), .din_s(din_s)
  );

  adc_spi_rx u_rx (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sclk_rise(sclk_rise),
    .din_s(din_s), .byte_vld(byte_vld), .byte_data(byte_data)
  );

  adc_spi_regs u_regs (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_data(byte_data),
    .conv(conv), .setup(setup), .avg(avg), .uni(uni_pairs), .bip(bip_pairs),
    .start(conv_start), .flush(queue_flush)
  );

  adc_spi_tx #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_tx (
    .clk(clk), .rst(rst), .cs_act(cs_act), .cs_start(cs_start),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .res_data(res_data), .res_valid(res_valid), .res_pop(res_pop),
    .dout(dout), .dout_oe(dout_oe)
  );

  assign chan_sel  = conv.chan;
  assign scan_mode = conv.scan;
  assign temp_req  = conv.temp;
  assign clk_mode  = setup.clk_mode;
  assign ref_mode  = setup.ref_mode;
  assign diff_sel  = setup.diff_sel;
  assign avg_en    = avg.en;
  assign avg_cnt   = avg.cnt;
endmodule

// File: rtl/adc_spi_ctrl_chk.sv
module adc_spi_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        cs_act,
  input logic        byte_vld,
  input logic        dout_oe,
  input logic        conv_start,
  input logic        res_pop,
  input logic        queue_flush,
  input logic [20:0] cfg
);
  p_start_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);
  p_start_from_byte_r3: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> $past(byte_vld));
  p_flush_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    queue_flush |=> !queue_flush);
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !byte_vld |=> $stable(cfg));
  p_pop_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    res_pop |=> !res_pop);
  p_pop_in_frame_r14: assert property (@(posedge clk) disable iff (rst)
    res_pop |-> $past(cs_act));
  p_oe_idle_r13: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !dout_oe);
endmodule

bind adc_spi_ctrl adc_spi_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act), .byte_vld(byte_vld),
  .dout_oe(dout_oe), .conv_start(conv_start), .res_pop(res_pop),
  .queue_flush(queue_flush),
  .cfg({chan_sel, scan_mode, temp_req, clk_mode, ref_mode, diff_sel,
        avg_en, avg_cnt, uni_pairs, bip_pairs})
);

// File: tb/adc_spi_ctrl_test.sv
module adc_spi_ctrl_test;
  localparam int HALF = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, din = 1'b0;
  logic dout, dout_oe, res_pop, conv_start, temp_req, avg_en, queue_flush;
  logic [11:0] res_data;
  logic        res_valid = 1'b0;
  logic [3:0]  chan_sel;
  logic [1:0]  scan_mode, clk_mode, ref_mode, diff_sel, avg_cnt, bip_pairs;
  logic [2:0]  uni_pairs;

  int checks = 0, fails = 0;
  int n_start = 0, n_pop = 0, n_flush = 0;
  int q_idx = 0;
  logic oe_in_frame;
  logic [11:0] q_mem [4] = '{12'hA5C, 12'h3F1, 12'h801, 12'h000};

  always #10 clk = ~clk;

  adc_spi_ctrl uut (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din),
    .dout(dout), .dout_oe(dout_oe), .res_data(res_data), .res_valid(res_valid),
    .res_pop(res_pop), .conv_start(conv_start), .chan_sel(chan_sel),
    .scan_mode(scan_mode), .temp_req(temp_req), .clk_mode(clk_mode),
    .ref_mode(ref_mode), .diff_sel(diff_sel), .avg_en(avg_en), .avg_cnt(avg_cnt),
    .uni_pairs(uni_pairs), .bip_pairs(bip_pairs), .queue_flush(queue_flush)
  );

  assign res_data = q_mem[q_idx];

  always @(posedge clk) begin
    if (conv_start)  n_start <= n_start + 1;
    if (queue_flush) n_flush <= n_flush + 1;
    if (res_pop) begin
      n_pop <= n_pop + 1;
      q_idx <= (q_idx + 1) % 4;
    end
  end

  // cmd[31:24] cfg[23:3] start[2] flush[1]
  localparam logic [31:0] VEC [11] = '{
    {8'hB5, 4'd6, 2'd2, 1'b1, 2'd2, 2'd0, 2'd0, 1'b0, 2'd0, 3'd0, 2'd0, 1'b1, 1'b0, 1'b0},
    {8'h5B, 4'd6, 2'd2, 1'b1, 2'd1, 2'd2, 2'd3, 1'b0, 2'd0, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0},
    {8'h3E, 4'd6, 2'd2, 1'b1, 2'd1, 2'd2, 2'd3, 1'b1, 2'd3, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0},
    {8'h0D, 4'd6, 2'd2, 1'b1, 2'd1, 2'd2, 2'd3, 1'b1, 2'd3, 3'd5, 2'd0, 1'b0, 1'b0, 1'b0},
    {8'h06, 4'd6, 2'd2, 1'b1, 2'd1, 2'd2, 2'd3, 1'b1, 2'd3, 3'd5, 2'd2, 1'b0, 1'b0, 1'b0},
    {8'h03, 4'd6, 2'd2, 1'b1, 2'd1, 2'd2, 2'd3, 1'b1, 2'd3, 3'd5, 2'd2, 1'b0, 1'b0, 1'b0},
    {8'h00, 4'd6, 2'd2, 1'b1, 2'd1, 2'd2, 2'd3, 1'b1, 2'd3, 3'd5, 2'd2, 1'b0, 1'b0, 1'b0},
    {8'h18, 4'd6, 2'd2, 1'b1, 2'd1, 2'd2, 2'd3, 1'b1, 2'd3, 3'd5, 2'd2, 1'b0, 1'b1, 1'b0},
    {8'h80, 4'd0, 2'd0, 1'b0, 2'd1, 2'd2, 2'd3, 1'b1, 2'd3, 3'd5, 2'd2, 1'b1, 1'b0, 1'b0},
    {8'h10, 4'd0, 2'd0, 1'b0, 2'd2, 2'd0, 2'd0, 1'b0, 2'd0, 3'd0, 2'd0, 1'b0, 1'b1, 1'b0},
    {8'hFF, 4'd15, 2'd3, 1'b1, 2'd2, 2'd0, 2'd0, 1'b0, 2'd0, 3'd0, 2'd0, 1'b1, 1'b0, 1'b0}
  };
  localparam string VREQ [11] = '{"R3", "R4", "R5", "R7", "R7", "R8", "R8", "R6",
                                  "R3", "R6", "R3"};

  function automatic logic [20:0] cfg_now();
    return {chan_sel, scan_mode, temp_req, clk_mode, ref_mode, diff_sel,
            avg_en, avg_cnt, uni_pairs, bip_pairs};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input int n, input logic [63:0] tx, output logic [63:0] rx);
    rx = '0;
    cs_n = 1'b0;
    repeat (8) @(posedge clk);
    #5 oe_in_frame = dout_oe;
    for (int i = n - 1; i >= 0; i--) begin
      din = tx[i];
      repeat (HALF) @(posedge clk);
      #5 rx[i] = dout;
      sclk = 1'b1;
      repeat (HALF) @(posedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(posedge clk);
    cs_n = 1'b1;
    din = 1'b0;
    repeat (8) @(posedge clk);
    #5;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    logic [63:0] rx;
    int s0, f0, p0;
    repeat (4) @(posedge clk);
    rst = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    // R2: reset values
    check("R2", 64'(cfg_now()), 64'({4'd0, 2'd0, 1'b0, 2'd2, 2'd0, 2'd0, 1'b0, 2'd0, 3'd0, 2'd0}));
    check("R2", 64'({dout_oe, conv_start, queue_flush, res_pop}), 64'd0);

    for (int v = 0; v < 11; v++) begin
      s0 = n_start;
      f0 = n_flush;
      xfer(8, 64'(VEC[v][31:24]), rx);
      check(VREQ[v], 64'(cfg_now()), 64'(VEC[v][23:3]));
      check(VREQ[v], 64'(n_start - s0), 64'(VEC[v][2]));
      check(VREQ[v], 64'(n_flush - f0), 64'(VEC[v][1]));
    end

    // R1: two commands inside one select-low frame
    s0 = n_start;
    xfer(16, 64'h5B80, rx);
    check("R1", 64'({chan_sel, scan_mode, temp_req, clk_mode, ref_mode, diff_sel}),
          64'({4'd0, 2'd0, 1'b0, 2'd1, 2'd2, 2'd3}));
    check("R1", 64'(n_start - s0), 64'd1);

    // R9: partial byte dropped on select release
    s0 = n_start;
    xfer(4, 64'hC, rx);
    xfer(8, 64'h34, rx);
    check("R9", 64'({avg_en, avg_cnt}), 64'({1'b1, 2'd1}));
    check("R9", 64'(n_start - s0), 64'd0);

    // R13: enable during frame and after
    check("R13", 64'(oe_in_frame), 64'd1);
    check("R13", 64'(dout_oe), 64'd0);

    // R10 R11: two words in one frame, din low (zero bytes, R8)
    res_valid = 1'b1;
    p0 = n_pop;
    xfer(32, 64'h0, rx);
    check("R10", rx[31:16], 64'h0A5C);
    check("R11", rx[15:0], 64'h03F1);
    check("R11", 64'(n_pop - p0), 64'd2);
    check("R8", 64'({avg_en, avg_cnt, clk_mode}), 64'({1'b1, 2'd1, 2'd1}));

    // R14: early release
    p0 = n_pop;
    xfer(10, 64'h0, rx);
    check("R14", rx[9:0], 64'(10'b0000100000));
    check("R14", 64'(n_pop - p0), 64'd0);

    // R12: queue empty
    res_valid = 1'b0;
    p0 = n_pop;
    xfer(16, 64'h0, rx);
    check("R12", rx[15:0], 64'h0);
    check("R12", 64'(n_pop - p0), 64'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule